// File: doc/BRIEF.md
# Prioritised Interrupt Collector

This block gathers up to 128 level-sensitive interrupt lines into a single processor request. Each line passes through a two-flop synchroniser, and then through a per-source control register that holds an enable flag and a two-bit priority level. An arbiter picks one winner from the sources that are pending, enabled and not blocked by an in-service level.

Software reaches the block over a simple word-addressed register bus with one-cycle read latency. To take an interrupt, the handler reads the status register to learn the winning source number. It writes that number to the vector register, which records the winner's level as in service. When handling ends, it writes the matching one-hot bit to the level-acknowledge register.

Every register decodes three aliases, selected by address bits [3:2]:
- 0 is a plain access.
- 1 is a set access.
- 2 is a clear access.
- 3 is unmapped.

A control register command returns all sources and the in-service state to their reset values.

Top module: `irq_collector`

## Requirements
- R1: After reset, the following hold:
  - every source reads 0 (disabled, level 0);
  - the in-service mask at 0x010 reads 0;
  - `irq` is low;
  - status at 0x070 reads 0x0000007F.
- R2: Source n has its control register at 0x120 + 16·n.
  - Bit 2 is the enable and bits [1:0] are the level. All other bits read 0.
  - Offset +0 writes the fields, +4 ORs in the written ones, and +8 clears the bits written as one.
  - A read at +0, +4 or +8 returns the fields in `rdata` one cycle after `rd_en`.
- R3: A change on `src` reaches arbitration through two flops. A source that is already enabled drives `irq` high after the second rising edge that follows its assertion, and not after the first.
- R4: Arbitration considers only sources that are pending and enabled. Among them, it picks the highest level, and equal levels go to the lowest source number.
- R5: Status has two fields:
  - bits [6:0] hold the winning source number;
  - bit 31 is set when a winner exists.

  With no winner, status reads 0x0000007F.
- R6: A write to the vector register at 0x000 (+0 or +4) sets in-service bit k, where k is the level of the source winning in that cycle. The in-service mask reads back at 0x010 bits [3:0].
  - A vector write at +8 has no effect.
  - A vector write with no winner has no effect.
- R7: While any level is in service, sources at or below the highest in-service level are not eligible, and sources above it still are.
- R8: A write to 0x010 at +0, +4 or +8 clears the in-service bits that are written as one. Bit k stands for level k.
- R9: `irq` is high exactly when a winner exists.
- R10: Writing bit 0 as one to the control register at 0x020 (+0 or +4) clears every source register and the in-service mask. The same write at +8 has no effect.
- R11: The following accesses are ignored on write and read as zero:
  - alias 3;
  - any address with bits [1:0] nonzero;
  - any offset not listed above, including source slots past the last one.

  The vector and control registers also read zero.
- R12: A vector write accepts the winner as it stands at the clock edge that samples the write. A source whose synchronised input rises at that same edge is not accepted, and it competes only from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | NUM_SRC | Raw level-sensitive interrupt lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The two functions that can fall in the same cycle are vector acceptance and the arrival of a new, higher-priority source at the synchroniser output. To provoke this, the bench raises a level-3 line one negative edge before it issues a vector write. The write is then sampled at the very edge where that line leaves the second flop. The result is judged correct when the in-service mask shows the older level-1 winner's bit and status then names the level-3 source, which is still above the in-service level.

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int NUM_SRC = 128,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int NLVL  = 4;
  localparam int BLK_W = ADDR_W - 4;
  localparam logic [BLK_W-1:0] B_VEC  = BLK_W'(0);
  localparam logic [BLK_W-1:0] B_ACK  = BLK_W'(1);
  localparam logic [BLK_W-1:0] B_CTL  = BLK_W'(2);
  localparam logic [BLK_W-1:0] B_STAT = BLK_W'(7);
  localparam logic [BLK_W-1:0] B_SRC0 = BLK_W'('h12);
  localparam logic [BLK_W:0]   NSRC_B = (BLK_W+1)'(NUM_SRC);
  localparam logic [1:0] M_PLAIN = 2'd0, M_SET = 2'd1, M_CLR = 2'd2;

  logic [NUM_SRC-1:0] s1, s2, en;
  logic [1:0]         lvl [NUM_SRC];
  logic [NLVL-1:0]    inserv;

  wire [BLK_W-1:0] blk  = addr[ADDR_W-1:4];
  wire [1:0]       mode = addr[3:2];
  wire             ok   = (addr[1:0] == 2'b00) && (mode != 2'd3);
  wire [BLK_W-1:0] soff = blk - B_SRC0;
  wire             in_src = ok && (blk >= B_SRC0) && ({1'b0, soff} < NSRC_B);
  wire [IDX_W-1:0] sidx = soff[IDX_W-1:0];
  wire             unused_wdata = ^wdata[DATA_W-1:4];

  wire wr_src = wr_en && in_src;
  wire wr_vec = wr_en && ok && (blk == B_VEC) && (mode != M_CLR);
  wire wr_ack = wr_en && ok && (blk == B_ACK);
  wire reinit = wr_en && ok && (blk == B_CTL) && (mode != M_CLR) && wdata[0];

  logic             top_on;
  logic [1:0]       top_lvl;
  logic             found;
  logic [IDX_W-1:0] win;
  logic [1:0]       wlvl;

  always_comb begin
    top_on  = 1'b0;
    top_lvl = 2'd0;
    for (int k = 0; k < NLVL; k++)
      if (inserv[k]) begin
        top_on  = 1'b1;
        top_lvl = 2'(k);
      end
  end

  always_comb begin
    found = 1'b0;
    win   = '1;
    wlvl  = 2'd0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (s2[i] && en[i] && (!top_on || lvl[i] > top_lvl) && (!found || lvl[i] >= wlvl)) begin
        found = 1'b1;
        win   = IDX_W'(i);
        wlvl  = lvl[i];
      end
  end

  assign irq = found;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= src;
      s2 <= s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en     <= '0;
      inserv <= '0;
      for (int i = 0; i < NUM_SRC; i++) lvl[i] <= 2'd0;
    end else if (reinit) begin
      en     <= '0;
      inserv <= '0;
      for (int i = 0; i < NUM_SRC; i++) lvl[i] <= 2'd0;
    end else begin
      if (wr_src)
        case (mode)
          M_PLAIN: begin
            en[sidx]  <= wdata[2];
            lvl[sidx] <= wdata[1:0];
          end
          M_SET: begin
            en[sidx]  <= en[sidx] | wdata[2];
            lvl[sidx] <= lvl[sidx] | wdata[1:0];
          end
          default: begin
            en[sidx]  <= en[sidx] & ~wdata[2];
            lvl[sidx] <= lvl[sidx] & ~wdata[1:0];
          end
        endcase
      if (wr_vec && found)
        inserv[wlvl] <= 1'b1;
      else if (wr_ack)
        inserv <= inserv & ~wdata[NLVL-1:0];
    end

  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (ok) begin
      if (blk == B_ACK)
        rd_val[NLVL-1:0] = inserv;
      else if (blk == B_STAT) begin
        rd_val[IDX_W-1:0] = win;
        rd_val[DATA_W-1]  = found;
      end else if (in_src)
        rd_val[2:0] = {en[sidx], lvl[sidx]};
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_val;

endmodule

module irq_collector_chk #(
  parameter int NUM_SRC = 128,
  parameter int ADDR_W  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [3:0]         wlow,
  input logic               stat_bit,
  input logic               irq,
  input logic [3:0]         inserv,
  input logic [NUM_SRC-1:0] en
);
  wire stat_rd = rd_en && (addr == ADDR_W'('h070));
  wire vec_wr  = wr_en && (addr == ADDR_W'('h000));
  wire ack_wr  = wr_en && (addr == ADDR_W'('h010));
  wire ctl_rst = wr_en && (addr == ADDR_W'('h020)) && wlow[0];

  assert_status_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (stat_bit == $past(irq)));

  assert_idle_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_wr && !irq) |=> $stable(inserv));

  assert_vector_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_wr && irq) |=> (inserv != 4'b0));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> ((inserv & $past(wlow)) == 4'b0));

  assert_reinit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rst |=> (inserv == 4'b0 && en == '0));

  assert_sync_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|$past(src, 2)));
endmodule

bind irq_collector irq_collector_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wlow(wdata[3:0]), .stat_bit(rdata[DATA_W-1]), .irq(irq), .inserv(inserv), .en(en));

// File: tb/irq_collector_bench.sv
module irq_collector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 128;
  localparam logic [11:0] A_VEC = 12'h000, A_ACK = 12'h010, A_CTL = 12'h020, A_STAT = 12'h070;
  localparam logic [31:0] NONE = 32'h0000_007F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_collector u_irq_collector (
    .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  function automatic logic [11:0] sa(int n, int m);
    return 12'(12'h120 + n * 16 + m * 4);
  endfunction

  function automatic logic [31:0] st(int n);
    return 32'h8000_0000 | 32'(n);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rchk(string tag, logic [11:0] a, logic [31:0] exp);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic settle;
    repeat (3) @(negedge clk);
  endtask

  task automatic clean;
    src = '0;
    wr(A_CTL, 32'h1);
    settle();
  endtask

  task automatic t_reset;
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    rchk("R1 status after reset", A_STAT, NONE);
    rchk("R1 in-service after reset", A_ACK, 32'h0);
    rchk("R1 source 5 after reset", sa(5, 0), 32'h0);
    rchk("R1 source 127 after reset", sa(127, 0), 32'h0);
  endtask

  task automatic t_aliases;
    wr(sa(3, 0), 32'h6);
    rchk("R2 plain write", sa(3, 0), 32'h6);
    wr(sa(3, 1), 32'h1);
    rchk("R2 set alias", sa(3, 0), 32'h7);
    wr(sa(3, 2), 32'h4);
    rchk("R2 clear alias", sa(3, 0), 32'h3);
    wr(sa(3, 0), 32'hFFFF_FFFF);
    rchk("R2 upper bits read zero", sa(3, 0), 32'h7);
    rchk("R2 read via set alias", sa(3, 1), 32'h7);
    rchk("R2 read via clear alias", sa(3, 2), 32'h7);
    wr(sa(3, 0), 32'h0);
  endtask

  task automatic t_sync;
    clean();
    wr(sa(10, 0), 32'h4);
    @(negedge clk); src[10] = 1'b1;
    @(negedge clk);
    chk("R3 irq after first edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R3 irq after second edge", {31'b0, irq}, 32'h1);
    rchk("R5 status names source 10", A_STAT, st(10));
  endtask

  task automatic t_arb;
    clean();
    wr(sa(30, 0), 32'h5);
    wr(sa(20, 0), 32'h5);
    wr(sa(40, 0), 32'h6);
    wr(sa(60, 0), 32'h4);
    src[20] = 1'b1; src[30] = 1'b1; src[40] = 1'b1; src[60] = 1'b1;
    settle();
    rchk("R4 highest level wins", A_STAT, st(40));
    src[40] = 1'b0; settle();
    rchk("R4 tie goes to lower number", A_STAT, st(20));
    src[20] = 1'b0; settle();
    rchk("R4 level 1 beats level 0", A_STAT, st(30));
    wr(sa(30, 2), 32'h4);
    rchk("R4 disabled source skipped", A_STAT, st(60));
    chk("R9 irq with winner", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_accept;
    clean();
    wr(sa(5, 0), 32'h5);
    wr(sa(9, 0), 32'h6);
    src[5] = 1'b1; src[9] = 1'b1;
    settle();
    rchk("R5 status before accept", A_STAT, st(9));
    wr(A_VEC, 32'd9);
    rchk("R6 level 2 in service", A_ACK, 32'h4);
    rchk("R7 lower level blocked", A_STAT, NONE);
    chk("R9 irq low when all blocked", {31'b0, irq}, 32'h0);
    wr(sa(12, 0), 32'h7);
    src[12] = 1'b1; settle();
    rchk("R7 higher level passes", A_STAT, st(12));
    wr(A_VEC + 12'h8, 32'd12);
    rchk("R6 clear alias on vector ignored", A_ACK, 32'h4);
    wr(A_VEC + 12'h4, 32'd12);
    rchk("R6 set alias accepts level 3", A_ACK, 32'hC);
    rchk("R7 level 3 in service blocks all", A_STAT, NONE);
    wr(A_ACK + 12'h8, 32'h8);
    rchk("R8 ack level 3 via clear alias", A_ACK, 32'h4);
    rchk("R7 level 3 eligible again", A_STAT, st(12));
    wr(A_ACK, 32'h4);
    rchk("R8 ack level 2 via plain", A_ACK, 32'h0);
    src = '0; settle();
    wr(A_VEC, 32'h0);
    rchk("R6 vector write with no winner", A_ACK, 32'h0);
  endtask

  task automatic t_same_cycle;
    clean();
    wr(sa(2, 0), 32'h5);
    wr(sa(50, 0), 32'h7);
    src[2] = 1'b1; settle();
    @(negedge clk); src[50] = 1'b1;
    wr(A_VEC, 32'd2);
    rchk("R12 older winner accepted", A_ACK, 32'h2);
    rchk("R12 new source wins next", A_STAT, st(50));
  endtask

  task automatic t_reinit;
    wr(A_CTL + 12'h8, 32'h1);
    rchk("R10 clear alias keeps source", sa(2, 0), 32'h5);
    rchk("R10 clear alias keeps in-service", A_ACK, 32'h2);
    wr(A_CTL + 12'h4, 32'h1);
    rchk("R10 source cleared", sa(50, 0), 32'h0);
    rchk("R10 in-service cleared", A_ACK, 32'h0);
    chk("R10 irq low after reinit", {31'b0, irq}, 32'h0);
    src = '0;
  endtask

  task automatic t_unmapped;
    wr(sa(7, 0), 32'h5);
    wr(sa(7, 3), 32'h2);
    rchk("R11 alias 3 write ignored", sa(7, 0), 32'h5);
    rchk("R11 alias 3 reads zero", sa(7, 3), 32'h0);
    wr(sa(7, 0) | 12'h1, 32'h0);
    rchk("R11 misaligned write ignored", sa(7, 0), 32'h5);
    wr(12'h030, 32'hFFFF_FFFF);
    rchk("R11 unmapped offset reads zero", 12'h030, 32'h0);
    wr(12'h920, 32'h7);
    rchk("R11 slot past end reads zero", 12'h920, 32'h0);
    rchk("R11 slot past end aliases nothing", sa(0, 0), 32'h0);
    rchk("R11 vector reads zero", A_VEC, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_aliases();
    t_sync();
    t_arb();
    t_accept();
    t_same_cycle();
    t_reinit();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule